// File: doc/BRIEF.md
# Selectable Clock Output Divider

This block produces one clock-output pin from a choice of six internal clock sources. A 3-bit source field picks the source (or turns the output off) and a 3-bit prescaler field divides the chosen source by a power of two, from 1 up to 128. The PLL source has a fixed halving stage that a control bit can bypass.

All sources are modelled as single-cycle enable strobes in one reference clock domain, so the whole block is ordinary synchronous logic. The output pin is a registered level in that domain. A status field reports the source code that is actually in effect. The block has no data stream, so all pins are plain control and status signals with no handshake. Switching sources or prescaler values while the output is running is allowed, but it may produce shortened or irregular output cycles. No glitch-free switch is attempted.

Top module: `clkout_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `clk_out` is 0 and `src_status` is 000.
- R2: Source code 000 (off) and code 001 (reserved) both hold `clk_out` at 0 and clear the prescaler counter.
- R3: Source codes select strobes in this order: 010 `lsi_tick`, 011 `lse_tick`, 100 `sys_tick`, 101 `hsi_tick`, 110 `hse_tick`, 111 `pll_tick`. Strobes that are not selected have no effect on `clk_out`.
- R4: `src_status` equals the effective code of `src_sel` from the previous cycle. Code 001 is reported as 000. The selection that drives `clk_out` changes in the same cycle as `src_status`.
- R5: For a prescaler code n from 1 to 7, a 7-bit counter counts the selected strobes. At each edge, `clk_out` takes bit n-1 of the counter value after that edge, which divides the source by 2^n.
- R6: For prescaler code 000, `clk_out` is 1 in exactly the cycle after each cycle in which the selected strobe is high.
- R7: With source 111 and `pll_nodiv` = 0, only every second `pll_tick` counts. After the selection takes effect, the second, fourth, and later ticks are the ones that pass.
- R8: With source 111 and `pll_nodiv` = 1, every `pll_tick` counts.
- R9: After the output has been turned off and is then selected again, counting restarts from zero, so the output phase does not depend on earlier history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lsi_tick | input | 1 | Low-speed internal source strobe |
| lse_tick | input | 1 | Low-speed external source strobe |
| sys_tick | input | 1 | System clock source strobe |
| hsi_tick | input | 1 | High-speed internal source strobe |
| hse_tick | input | 1 | High-speed external source strobe |
| pll_tick | input | 1 | PLL source strobe |
| src_sel | input | 3 | Source select code |
| pre_sel | input | 3 | Prescaler code n, divide by 2^n |
| pll_nodiv | input | 1 | 1 bypasses the PLL halving stage |
| clk_out | output | 1 | Divided clock output level |
| src_status | output | 3 | Effective source code in use |

## Verification
Each strobe runs with its own period (7, 5, 1, 2 and 3 cycles, and the PLL every cycle). Because the periods differ, selecting the wrong source changes the output waveform. All seven prescaler codes are run on the every-cycle system strobe, which separates off-by-one bit choices. The PLL is run both with and without halving, which shows whether the halving stage is applied. A final stretch changes the source every two cycles to check the status timing and the restart of counting after the output is turned off.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  localparam int SEL_W = 3;
  localparam int NSRC  = 6;
  localparam int FIRST_SRC_CODE = 2;

  typedef enum logic [SEL_W-1:0] {
    SRC_OFF  = 3'd0,
    SRC_RSVD = 3'd1,
    SRC_LSI  = 3'd2,
    SRC_LSE  = 3'd3,
    SRC_SYS  = 3'd4,
    SRC_HSI  = 3'd5,
    SRC_HSE  = 3'd6,
    SRC_PLL  = 3'd7
  } src_code_e;

  function automatic logic [SEL_W-1:0] eff_code(input logic [SEL_W-1:0] c);
    return (c == SRC_RSVD) ? SRC_OFF : c;
  endfunction
endpackage

// File: rtl/clkout_src_sel.sv
module clkout_src_sel
  import clkout_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_cfg,
  input  logic             pll_nodiv,
  input  logic [NSRC-1:0]  src_ticks,
  output logic             tick_out,
  output logic             src_on,
  output logic [SEL_W-1:0] status
);
  localparam int PLL_IDX = NSRC - 1;

  logic [SEL_W-1:0] sel_q;
  logic             half_q;
  logic [NSRC-1:0]  ticks_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= SRC_OFF;
      half_q <= 1'b0;
    end else begin
      sel_q <= eff_code(sel_cfg);
      if (sel_q != SRC_PLL)
        half_q <= 1'b0;
      else if (src_ticks[PLL_IDX])
        half_q <= ~half_q;
    end
  end

  assign ticks_eff = {src_ticks[PLL_IDX] & (pll_nodiv | half_q),
                      src_ticks[PLL_IDX-1:0]};

  assign src_on = (sel_q >= SEL_W'(FIRST_SRC_CODE));
  assign status = sel_q;

  always_comb begin
    tick_out = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (sel_q == SEL_W'(i + FIRST_SRC_CODE))
        tick_out = ticks_eff[i];
    end
  end

  // R4
  status_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> status == eff_code($past(sel_cfg)));

  // R7
  pll_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == SRC_PLL && !pll_nodiv && tick_out)
      |=> (sel_q != SRC_PLL || pll_nodiv || !tick_out));

  // R3
  pll_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == SRC_PLL && tick_out) |-> src_ticks[PLL_IDX]);
endmodule

// File: rtl/clkout_prescaler.sv
module clkout_prescaler #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_on,
  input  logic             tick,
  input  logic [PRE_W-1:0] pre_sel,
  output logic             pin
);
  localparam int CNT_W = (1 << PRE_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W:0]   tap_vec;

  assign cnt_nxt = cnt_q + CNT_W'(tick);
  assign tap_vec = {cnt_nxt, tick};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pin   <= 1'b0;
    end else if (!src_on) begin
      cnt_q <= '0;
      pin   <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      pin   <= tap_vec[pre_sel];
    end
  end

  // R2
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !src_on |=> (!pin && cnt_q == '0));

  // R6
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_on && pre_sel == '0) |=> pin == $past(tick));

  // R5
  hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_on && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/clkout_gen.sv
module clkout_gen
  import clkout_pkg::*;
#(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lsi_tick,
  input  logic             lse_tick,
  input  logic             sys_tick,
  input  logic             hsi_tick,
  input  logic             hse_tick,
  input  logic             pll_tick,
  input  logic [2:0]       src_sel,
  input  logic [PRE_W-1:0] pre_sel,
  input  logic             pll_nodiv,
  output logic             clk_out,
  output logic [2:0]       src_status
);
  logic [NSRC-1:0] ticks;
  logic            sel_tick;
  logic            sel_on;

  assign ticks = {pll_tick, hse_tick, hsi_tick, sys_tick, lse_tick, lsi_tick};

  clkout_src_sel u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_cfg   (src_sel),
    .pll_nodiv (pll_nodiv),
    .src_ticks (ticks),
    .tick_out  (sel_tick),
    .src_on    (sel_on),
    .status    (src_status)
  );

  clkout_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_on  (sel_on),
    .tick    (sel_tick),
    .pre_sel (pre_sel),
    .pin     (clk_out)
  );

  // R9
  restart_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_on) |-> !clk_out);
endmodule

// File: tb/clkout_gen_tb_top.sv
module clkout_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lsi_tick = 0, lse_tick = 0, sys_tick = 0, hsi_tick = 0, hse_tick = 0, pll_tick = 0;
  logic [2:0] src_sel = 3'd0;
  logic [2:0] pre_sel = 3'd0;
  logic pll_nodiv = 1'b0;
  logic clk_out;
  logic [2:0] src_status;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;
  string cur_req = "R1";

  int m_sel = 0;
  int m_half = 0;
  int m_cnt = 0;
  int m_pin = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkout_gen dut_i (
    .clk(clk), .rst_n(rst_n),
    .lsi_tick(lsi_tick), .lse_tick(lse_tick), .sys_tick(sys_tick),
    .hsi_tick(hsi_tick), .hse_tick(hse_tick), .pll_tick(pll_tick),
    .src_sel(src_sel), .pre_sel(pre_sel), .pll_nodiv(pll_nodiv),
    .clk_out(clk_out), .src_status(src_status)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic drive_ticks();
    lsi_tick = (cyc % 7) == 0;
    lse_tick = (cyc % 5) == 1;
    sys_tick = 1'b1;
    hsi_tick = (cyc % 2) == 0;
    hse_tick = (cyc % 3) == 2;
    pll_tick = 1'b1;
  endtask

  task automatic model_edge();
    int t;
    int nxt;
    int nh;
    case (m_sel)
      2: t = lsi_tick;
      3: t = lse_tick;
      4: t = sys_tick;
      5: t = hsi_tick;
      6: t = hse_tick;
      7: t = pll_tick && (pll_nodiv || m_half != 0);
      default: t = 0;
    endcase
    nh = (m_sel != 7) ? 0 : (pll_tick ? 1 - m_half : m_half);
    if (m_sel == 0) begin
      m_cnt = 0;
      m_pin = 0;
    end else begin
      nxt = (m_cnt + t) % 128;
      m_pin = (pre_sel == 0) ? t : ((nxt >> (pre_sel - 1)) & 1);
      m_cnt = nxt;
    end
    m_half = nh;
    m_sel = (src_sel == 3'd1) ? 0 : int'(src_sel);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cyc++;
    check(cur_req, int'(clk_out), m_pin);
    check("R4", int'(src_status), m_sel);
    drive_ticks();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic cfg(input string req, input int s, input int p, input bit nd, input int n);
    cur_req = req;
    src_sel = 3'(s);
    pre_sel = 3'(p);
    pll_nodiv = nd;
    run(n);
  endtask

  initial begin
    drive_ticks();
    repeat (3) @(negedge clk);
    check("R1", int'(clk_out), 0);
    check("R1", int'(src_status), 0);
    rst_n = 1'b1;
    run(2);

    // R2: reserved and off codes
    cfg("R2", 1, 0, 0, 30);
    cfg("R2", 0, 3, 0, 10);
    // R6: pass-through
    cfg("R6", 4, 0, 0, 20);
    cfg("R6", 5, 0, 0, 20);
    cfg("R6", 2, 0, 0, 30);
    // R3: source order
    for (int s = 2; s <= 6; s++) cfg("R3", s, 2, 0, 60);
    for (int s = 2; s <= 6; s++) cfg("R3", s, 0, 0, 30);
    // R5: all prescaler codes
    cfg("R5", 0, 0, 0, 3);
    for (int p = 1; p <= 7; p++) cfg("R5", 4, p, 0, 300);
    // R7: halved PLL
    cfg("R7", 0, 0, 0, 3);
    cfg("R7", 7, 0, 0, 40);
    cfg("R7", 7, 3, 0, 100);
    // R8: undivided PLL
    cfg("R8", 0, 0, 1, 3);
    cfg("R8", 7, 0, 1, 40);
    cfg("R8", 7, 3, 1, 100);
    // R9: restart after off
    cfg("R9", 3, 1, 0, 23);
    cfg("R9", 0, 1, 0, 3);
    cfg("R9", 3, 1, 0, 40);
    cfg("R9", 1, 2, 0, 2);
    cfg("R9", 7, 2, 0, 40);
    // R4: rapid switching
    for (int k = 0; k < 40; k++) cfg("R4", (k * 5 + 3) % 8, k % 4, k[0], 2);
    cfg("R2", 0, 0, 0, 5);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d actual=hung expected=done", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule